// File: doc/BRIEF.md
# Switch Command Latch and Lockout Controller

This block is the digital control core of a multi-switch line interface. It turns a vector of per-switch command bits into the effective switch-state vector. An active-low latch enable chooses between two modes. In transparent mode the commands pass through. In hold mode the switch state is frozen at the moment the enable rises. Two kinds of all-off request override the latched state without disturbing it. One is an internal over-temperature flag. The other is an active-low request read from a shared open-drain fault pin, which the block itself pulls low while it is over temperature.

A supply-valid indication from an external voltage detector acts as the block's reset. It is asserted asynchronously and released synchronously. While the supply is invalid, every switch is off. Once the supply is valid, the block keeps every switch off until the latch enable has actually been seen low. A card inserted with the enable high or undriven therefore stays in all-off for as long as that lasts. The latch enable and the fault pin each pass through a two-stage synchronizer before use.

Top module: `swLockoutCtl`

## Requirements
- R1: While `supplyOk` is 0, `swState` is all zeros and `faultDriveLow` is 0. A falling `supplyOk` clears `swState` at once, without waiting for a clock edge.
- R2: Reset is released on the second rising clock edge after `supplyOk` rises. After that, `swState` stays all zeros until `latchN` has been sampled at 0 and has passed through its two-stage synchronizer. An undriven `latchN` reads as 1. If `latchN` is already 0 at power-up, the commanded state appears within eight clock cycles of `supplyOk` rising.
- R3: In run mode with `latchN` at 0 and no all-off request, `swState` equals the `swCmd` value sampled at the previous rising edge.
- R4: While the synchronized `latchN` is 1, changes on `swCmd` have no effect on `swState`. The state captured before the enable rose is held.
- R5: A 1 on `thermFault` forces `swState` to all zeros in the same cycle, whatever the latch mode. From the next rising edge, `faultDriveLow` equals `thermFault` as sampled at the previous edge.
- R6: A 0 on `extOffPinN` that is present at two consecutive rising edges forces `swState` to all zeros from the second of those edges on, whatever the latch mode.
- R7: When an all-off request clears while the synchronized `latchN` is 1, `swState` returns to the state frozen before the request, not to the current `swCmd`.
- R8: When an all-off request clears while `latchN` is 0, `swState` shows the current `swCmd`. Capture continues throughout the request.
- R9: A supply loss during run mode returns the block to lockout. On the next power-up the hold of R2 applies again: the switches stay off until `latchN` is seen low once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| supplyOk | input | 1 | Supply-valid indication; low acts as asynchronous reset |
| latchN | input | 1 | Latch enable: 0 = transparent, 1 = hold (asynchronous) |
| swCmd | input | NUM_SW | Per-switch command bits, 1 = switch on |
| thermFault | input | 1 | Over-temperature flag, active high, synchronous to clk |
| extOffPinN | input | 1 | Level read from the shared fault pin, low = all-off request (asynchronous) |
| swState | output | NUM_SW | Effective switch-state vector, 1 = switch on |
| faultDriveLow | output | 1 | Drive-low enable for the shared fault pin |

## Verification
The hardest state to reach is an all-off request that clears while the latch is in hold mode, after the command inputs have moved on. The stimulus first freezes a known pattern with the latch enable high. It then changes the commands, raises the thermal flag or pulls the shared pin low, and releases the request, so the frozen pattern must come back. The thermal case also runs through the block's own drive of the shared pin, which extends the request by the synchronizer delay. Power-up is driven from every pairing of defined or undefined commands with the latch enable at 0, at 1 or left floating on a pulled-up net.

// File: rtl/switchCtlPkg.sv
package switchCtlPkg;

  typedef enum logic [1:0] {
    ST_LOCKOUT  = 2'd0,
    ST_WAIT_LOW = 2'd1,
    ST_RUN      = 2'd2
  } ctlState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic captureEn;   // load the frozen state from the command inputs
    logic forceOff;    // gate every switch off
  } dpStrobe_t;

endpackage

// File: rtl/swResetSync.sv
module swResetSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic supplyOk,
  output logic rstN
);
  logic [STAGES-1:0] rstQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge supplyOk) begin
        if (!supplyOk) rstQ <= 1'b0;
        else           rstQ <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge supplyOk) begin
        if (!supplyOk) rstQ <= '0;
        else           rstQ <= {rstQ[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rstN = rstQ[STAGES-1];
endmodule

// File: rtl/swBitSync.sv
module swBitSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] syncQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= RESET_VAL;
        else       syncQ <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= {STAGES{RESET_VAL}};
        else       syncQ <= {syncQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = syncQ[STAGES-1];
endmodule

// File: rtl/swCtlFsm.sv
module swCtlFsm
  import switchCtlPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      latchSyncN,
  input  logic      extSyncN,
  input  logic      thermFault,
  output dpStrobe_t strobe
);
  ctlState_t stateQ, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_LOCKOUT;
    else       stateQ <= stateNext;
  end

  always_comb begin
    stateNext = stateQ;
    case (stateQ)
      ST_LOCKOUT:  stateNext = ST_WAIT_LOW;
      ST_WAIT_LOW: if (!latchSyncN) stateNext = ST_RUN;
      ST_RUN:      stateNext = ST_RUN;
      default:     stateNext = ST_LOCKOUT;
    endcase
  end

  // Capture also runs while waiting, so that run mode starts with fresh commands.
  always_comb begin
    strobe.captureEn = (stateQ != ST_LOCKOUT) && !latchSyncN;
    strobe.forceOff  = (stateQ != ST_RUN) || thermFault || !extSyncN;
  end
endmodule

// File: rtl/swDatapath.sv
module swDatapath
  import switchCtlPkg::*;
#(
  parameter int NUM_SW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [NUM_SW-1:0] swCmd,
  input  logic              thermFault,
  output logic [NUM_SW-1:0] swState,
  output logic              faultDriveLow
);
  logic [NUM_SW-1:0] frozenQ;
  logic              faultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 frozenQ <= '0;
    else if (strobe.captureEn) frozenQ <= swCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultQ <= 1'b0;
    else       faultQ <= thermFault;
  end

  generate
    for (genvar i = 0; i < NUM_SW; i++) begin : g_gate
      assign swState[i] = frozenQ[i] & ~strobe.forceOff;
    end
  endgenerate

  assign faultDriveLow = faultQ;
endmodule

// File: rtl/swLockoutCtl.sv
module swLockoutCtl
  import switchCtlPkg::*;
#(
  parameter int NUM_SW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              supplyOk,
  input  logic              latchN,
  input  logic [NUM_SW-1:0] swCmd,
  input  logic              thermFault,
  input  logic              extOffPinN,
  output logic [NUM_SW-1:0] swState,
  output logic              faultDriveLow
);
  logic      rstN;
  logic      latchSyncN;
  logic      extSyncN;
  dpStrobe_t strobe;

  swResetSync #(.STAGES(SYNC_STAGES)) u_rstSync (
    .clk(clk), .supplyOk(supplyOk), .rstN(rstN)
  );

  swBitSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_latchSync (
    .clk(clk), .rstN(rstN), .din(latchN), .dout(latchSyncN)
  );

  swBitSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_extSync (
    .clk(clk), .rstN(rstN), .din(extOffPinN), .dout(extSyncN)
  );

  swCtlFsm u_fsm (
    .clk(clk), .rstN(rstN), .latchSyncN(latchSyncN), .extSyncN(extSyncN),
    .thermFault(thermFault), .strobe(strobe)
  );

  swDatapath #(.NUM_SW(NUM_SW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .swCmd(swCmd),
    .thermFault(thermFault), .swState(swState), .faultDriveLow(faultDriveLow)
  );
endmodule

// File: rtl/swLockoutCtl_chk.sv
module swLockoutCtl_chk #(
  parameter int NUM_SW = 4
) (
  input logic              clk,
  input logic              supplyOk,
  input logic              rstN,
  input logic              latchN,
  input logic              thermFault,
  input logic              extOffPinN,
  input logic [NUM_SW-1:0] swState,
  input logic              faultDriveLow
);
  logic seenLowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenLowQ <= 1'b0;
    else if (!latchN) seenLowQ <= 1'b1;
  end

  // R1: supply invalid means every switch off and no pin drive
  always @(negedge clk) begin
    if (supplyOk === 1'b0)
      assert_lockout_off_R1: assert (swState == '0 && !faultDriveLow);
  end

  assert_hold_until_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (swState != '0) |-> seenLowQ);

  assert_therm_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    thermFault |-> (swState == '0));

  assert_pin_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |=> (faultDriveLow == $past(thermFault)));

  assert_ext_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(extOffPinN) && !extOffPinN) |=> (swState == '0));
endmodule

bind swLockoutCtl swLockoutCtl_chk #(.NUM_SW(NUM_SW)) u_chk (
  .clk(clk), .supplyOk(supplyOk), .rstN(rstN), .latchN(latchN),
  .thermFault(thermFault), .extOffPinN(extOffPinN), .swState(swState),
  .faultDriveLow(faultDriveLow)
);

// File: tb/swLockoutCtl_bench.sv
`timescale 1ns/100ps
module swLockoutCtl_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         supplyOk = 1'b0;
  logic         latchDrvEn = 1'b1;
  logic         latchDrvVal = 1'b1;
  logic [N-1:0] swCmd = '0;
  logic         thermFault = 1'b0;
  logic         extDrvLow = 1'b0;
  wire          latchNet;
  wire          extNet;
  wire  [N-1:0] swState;
  wire          faultDriveLow;

  assign latchNet = latchDrvEn ? latchDrvVal : 1'bz;
  pullup (latchNet);
  assign extNet = (extDrvLow || faultDriveLow) ? 1'b0 : 1'bz;
  pullup (extNet);

  always #2 clk = ~clk;

  swLockoutCtl #(.NUM_SW(N), .SYNC_STAGES(2)) u_swLockoutCtl (
    .clk(clk), .supplyOk(supplyOk), .latchN(latchNet), .swCmd(swCmd),
    .thermFault(thermFault), .extOffPinN(extNet), .swState(swState),
    .faultDriveLow(faultDriveLow)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R1";
  bit    finished = 1'b0;

  // Behavioural reference: mode 0 lockout, 1 waiting for latch low, 2 run
  int           mMode   = 0;
  int           mRstCnt = 0;
  bit           mRstOk  = 1'b0;
  logic [N-1:0] mHeld   = '0;
  logic         mFd     = 1'b0;
  logic         latchQ[$] = '{1'b1, 1'b1};
  logic         extQ[$]   = '{1'b1, 1'b1};
  bit           mTake;

  always @(posedge clk or negedge supplyOk) begin
    if (!supplyOk) begin
      mRstCnt = 0; mRstOk = 1'b0; mMode = 0; mHeld = '0; mFd = 1'b0;
      latchQ = '{1'b1, 1'b1}; extQ = '{1'b1, 1'b1};
    end else begin
      if (mRstOk) begin
        mTake = (mMode != 0) && (latchQ[0] == 1'b0);
        if (mTake) mHeld = swCmd;
        if (mMode == 0) mMode = 1;
        else if (mMode == 1 && latchQ[0] == 1'b0) mMode = 2;
        void'(latchQ.pop_front());
        latchQ.push_back(latchNet);
        void'(extQ.pop_front());
        extQ.push_back(!(mFd || extDrvLow));
        mFd = thermFault;
      end
      if (mRstCnt < 2) mRstCnt++;
      mRstOk = (mRstCnt >= 2);
    end
  end

  function automatic logic [N-1:0] modelOut();
    if (!mRstOk || mMode != 2 || thermFault || extQ[0] == 1'b0) return '0;
    return mHeld;
  endfunction

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      nChecks++;
      if (swState !== modelOut() || faultDriveLow !== (mRstOk ? mFd : 1'b0)) begin
        nFails++;
        $display("FAIL %s cycle compare: swState=%b fd=%b expected %b fd=%b",
                 curReq, swState, faultDriveLow, modelOut(), mRstOk ? mFd : 1'b0);
      end
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic setLatch(int lmode);
    if (lmode == 2) latchDrvEn = 1'b0;
    else begin latchDrvEn = 1'b1; latchDrvVal = (lmode == 1); end
  endtask

  task automatic powerUp(bit defined, int lmode, logic [N-1:0] cmd);
    curReq = "R1";
    supplyOk = 1'b0;
    swCmd = defined ? cmd : 'x;
    setLatch(lmode);
    waitCyc(3);
    chk("R1", swState, '0, "all-off while supply invalid");
    chk("R1", {{(N-1){1'b0}}, faultDriveLow}, '0, "no pin drive while supply invalid");
    curReq = "R2";
    supplyOk = 1'b1;
    waitCyc(8);
    if (defined && lmode == 0)
      chk("R2", swState, cmd, "power-up with latch low applies commands");
    else if (lmode != 0)
      chk("R2", swState, '0, "power-up with latch high or floating stays off");
    swCmd = cmd;
    setLatch(0);
    waitCyc(5);
    chk("R2", swState, cmd, "release after latch seen low");
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete");
      finished = 1'b1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    waitCyc(2);
    chk("R1", swState, '0, "reset state");

    // R2: six power-up combinations
    for (int d = 1; d >= 0; d--)
      for (int l = 0; l < 3; l++)
        powerUp(d[0], l, 4'(4'b0101 + d * 3 + l));

    // R3: transparent mode
    curReq = "R3";
    begin
      logic [N-1:0] pats[4] = '{4'b0000, 4'b1111, 4'b1010, 4'b0110};
      foreach (pats[i]) begin
        swCmd = pats[i];
        waitCyc(1);
        chk("R3", swState, pats[i], "transparent one-cycle follow");
      end
    end

    // R4: hold ignores command changes
    curReq = "R4";
    swCmd = 4'b1001;
    waitCyc(1);
    setLatch(1);
    waitCyc(3);
    swCmd = 4'b0111;
    waitCyc(3);
    chk("R4", swState, 4'b1001, "held state after command change");
    swCmd = 4'b1110;
    waitCyc(3);
    chk("R4", swState, 4'b1001, "held state after second command change");

    // R5 / R7: thermal request during hold
    curReq = "R5";
    thermFault = 1'b1;
    #0.5;
    chk("R5", swState, '0, "thermal forces off same cycle");
    waitCyc(1);
    chk("R5", {{(N-1){1'b0}}, faultDriveLow}, 4'b0001, "pin driven low while hot");
    swCmd = 4'b0011;
    waitCyc(2);
    curReq = "R7";
    thermFault = 1'b0;
    waitCyc(6);
    chk("R7", swState, 4'b1001, "frozen state restored after thermal clear");
    chk("R5", {{(N-1){1'b0}}, faultDriveLow}, '0, "pin released after thermal clear");

    // R6 / R7: external request during hold
    curReq = "R6";
    extDrvLow = 1'b1;
    waitCyc(3);
    chk("R6", swState, '0, "external pin low forces off in hold");
    swCmd = 4'b0100;
    waitCyc(2);
    curReq = "R7";
    extDrvLow = 1'b0;
    waitCyc(4);
    chk("R7", swState, 4'b1001, "frozen state restored after external clear");

    // R8: request clears with latch low
    curReq = "R8";
    setLatch(0);
    waitCyc(4);
    extDrvLow = 1'b1;
    waitCyc(3);
    chk("R6", swState, '0, "external pin low forces off in transparent mode");
    swCmd = 4'b1100;
    waitCyc(2);
    extDrvLow = 1'b0;
    waitCyc(4);
    chk("R8", swState, 4'b1100, "current commands after clear in transparent mode");

    // R9: supply loss from run mode
    curReq = "R9";
    supplyOk = 1'b0;
    #0.5;
    chk("R1", swState, '0, "supply fall clears switches at once");
    waitCyc(2);
    setLatch(1);
    swCmd = 4'b0111;
    supplyOk = 1'b1;
    waitCyc(10);
    chk("R9", swState, '0, "hold after supply return with latch high");
    setLatch(0);
    waitCyc(5);
    chk("R9", swState, 4'b0111, "commands applied after latch low again");

    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule